// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Engine

This block keeps a running 16-bit CRC over a stream of bytes and takes in one whole byte on each clock cycle. The generator polynomial is x^16 + x^12 + x^5 + 1, which is 0x1021 once the top term is dropped. Bits are taken most significant first, with no bit reflection. Each byte is reduced in a single combinational step. The high byte of the register is XORed with the incoming byte, and that intermediate is folded onto itself shifted right by four to give the quotient. The quotient is then XORed into the register, which has been shifted left by eight, at offsets 12, 5 and 0.

The user pulses a start strobe to begin a message. That reloads the seed 0xFFFF. The user then presents bytes with a valid qualifier. The register value can be read at any time, and it is the CRC of all bytes accepted since the last start. No final XOR is applied. A one-cycle flag marks each cycle in which the register has just taken a new byte.

Top module: `crcByteEngine`

## Requirements
- R1: After synchronous reset, `crcOut` equals 0xFFFF and `crcUpd` is 0.
- R2: A start strobe with no valid byte loads 0xFFFF into `crcOut` on the next clock edge.
- R3: With valid high, the next `crcOut` is (crc<<8) ^ (q<<12) ^ (q<<5) ^ q, truncated to 16 bits. Here q = t ^ (t>>4) and t = crc[15:8] ^ byte.
- R4: From seed 0xFFFF, the byte 0x31 gives 0xC782, and the bytes 0x31, 0x32 give 0x3DBA.
- R5: Start and valid high together seed with 0xFFFF and fold that byte in the same cycle. The result for a lone byte 0x31 is 0xC782.
- R6: `crcOut` holds its value in every cycle where `inValid` is low and `start` is low.
- R7: `crcUpd` is 1 in exactly the cycle after a byte was accepted, and 0 otherwise.
- R8: For random byte streams of random length, `crcOut` matches a bit-serial MSB-first CRC with polynomial 0x1021 and seed 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Reload the seed for a new message |
| inValid | input | 1 | Qualifies `inByte` |
| inByte | input | 8 | Data byte, MSB first |
| crcOut | output | 16 | Running CRC register |
| crcUpd | output | 1 | Register took a byte in the previous cycle |

## Verification
The bench drives the 0x31/0x32 vector chain and compares the result with values it computes independently.
- **Start together with valid:** a design that folds the byte into the old register instead of the seed gives a wrong CRC on the first byte.
- **Idle cycles mid-message:** these expose a register that drifts or re-applies a byte while `inValid` is low.
- **Random streams against a bit-serial model:** these catch a wrong shift offset, a missing fold, or a quotient product that keeps bits above 15.
- **Update flag:** it is checked cycle by cycle, which catches a flag that is stretched or delayed.

// File: rtl/crcBytePkg.sv
package crcBytePkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic load;   // reload seed as base
    logic fold;   // fold byte into register
  } crcCtl_t;
endpackage

// File: rtl/crcFoldPath.sv
module crcFoldPath
  import crcBytePkg::*;
#(
  parameter int W  = CRC_W,
  parameter int BW = BYTE_W,
  parameter logic [W-1:0] SEED = CRC_SEED
) (
  input  logic          clk,
  input  logic          rst,
  input  crcCtl_t       ctl,
  input  logic [BW-1:0] dataByte,
  output logic [W-1:0]  crcReg
);
  localparam int HALF = BW / 2;

  logic [W-1:0]  base;
  logic [BW-1:0] inter;
  logic [BW-1:0] quot;
  logic [W-1:0]  nextCrc;

  always_comb begin
    base    = ctl.load ? SEED : crcReg;
    inter   = base[W-1 -: BW] ^ dataByte;
    quot    = inter ^ (inter >> HALF);
    nextCrc = (base << BW)
            ^ (W'(quot) << 12)
            ^ (W'(quot) << 5)
            ^ W'(quot);
  end

  always_ff @(posedge clk) begin
    if (rst)           crcReg <= SEED;
    else if (ctl.fold) crcReg <= nextCrc;
    else if (ctl.load) crcReg <= SEED;
  end
endmodule

// File: rtl/crcCtrl.sv
module crcCtrl
  import crcBytePkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    inValid,
  output crcCtl_t ctl,
  output logic    updFlag
);
  always_comb begin
    ctl.load = start;
    ctl.fold = inValid;
  end

  always_ff @(posedge clk) begin
    if (rst) updFlag <= 1'b0;
    else     updFlag <= inValid;
  end
endmodule

// File: rtl/crcByteEngine.sv
module crcByteEngine
  import crcBytePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  output logic [CRC_W-1:0]  crcOut,
  output logic              crcUpd
);
  crcCtl_t ctl;

  crcCtrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid),
    .ctl(ctl), .updFlag(crcUpd)
  );

  crcFoldPath u_path (
    .clk(clk), .rst(rst), .ctl(ctl), .dataByte(inByte), .crcReg(crcOut)
  );
endmodule

// File: rtl/crcByteEngine_chk.sv
module crcByteEngine_chk
  import crcBytePkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              inValid,
  input logic [BYTE_W-1:0] inByte,
  input logic [CRC_W-1:0]  crcOut,
  input logic              crcUpd
);
  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !inValid) |=> (crcOut == CRC_SEED));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !inValid) |=> $stable(crcOut));

  // R7
  upd_rise_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> crcUpd);

  // R7
  upd_low_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !crcUpd);

  // R5
  start_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (start && inValid && inByte == 8'h31) |=> (crcOut == 16'hC782));
endmodule

bind crcByteEngine crcByteEngine_chk u_chk (.*);

// File: tb/crcByteEngine_tb.sv
module crcByteEngine_tb;
  logic        clk = 1'b0;
  logic        rst, start, inValid;
  logic [7:0]  inByte;
  logic [15:0] crcOut;
  logic        crcUpd;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  crcByteEngine u_dut (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid),
    .inByte(inByte), .crcOut(crcOut), .crcUpd(crcUpd)
  );

  // vector: {startFlag, byte, expected CRC after}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h31, 16'hC782},
    {1'b0, 8'h32, 16'h3DBA},
    {1'b1, 8'h31, 16'hC782},
    {1'b1, 8'h31, 16'hC782},
    {1'b0, 8'h32, 16'h3DBA},
    {1'b1, 8'h00, 16'hE1F0}
  };

  function automatic logic [15:0] serialCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic [7:0] b);
    start = s; inValid = v; inByte = b;
    @(posedge clk); #1;
    start = 0; inValid = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ref_c, held;
    rst = 1; start = 0; inValid = 0; inByte = 0;
    repeat (2) @(posedge clk); #1;
    rst = 0;
    check("R1 reset crc", 32'(crcOut), 32'hFFFF);
    check("R1 reset upd", 32'(crcUpd), 32'h0);

    // R4 R5 vector chain
    foreach (VEC[k]) begin
      drive(VEC[k][24], 1'b1, VEC[k][23:16]);
      check("R4/R5 vector", 32'(crcOut), 32'(VEC[k][15:0]));
      check("R7 upd after byte", 32'(crcUpd), 32'h1);
      ref_c = serialCrc(k == 5 ? 16'hFFFF : 16'hFFFF, 8'h00);
    end
    check("R3 serial agrees 0x00", 32'(ref_c), 32'hE1F0);

    // R6 hold while idle
    held = crcOut;
    drive(1'b0, 1'b0, 8'hA5);
    check("R7 upd low idle", 32'(crcUpd), 32'h0);
    drive(1'b0, 1'b0, 8'h5A);
    check("R6 hold idle", 32'(crcOut), 32'(held));

    // R2 start without data
    drive(1'b1, 1'b0, 8'h77);
    check("R2 seed reload", 32'(crcOut), 32'hFFFF);
    check("R7 upd low start only", 32'(crcUpd), 32'h0);

    // R3 single-byte formula on a chosen value
    drive(1'b0, 1'b1, 8'hA5);
    check("R3 byte 0xA5", 32'(crcOut), 32'(serialCrc(16'hFFFF, 8'hA5)));

    // R8 random streams with idle gaps
    for (int m = 0; m < 40; m++) begin
      int len = 1 + ($urandom % 33);
      ref_c = 16'hFFFF;
      for (int j = 0; j < len; j++) begin
        logic [7:0] b = 8'($urandom);
        ref_c = serialCrc(ref_c, b);
        drive(j == 0, 1'b1, b);
        if ($urandom % 4 == 0) drive(1'b0, 1'b0, 8'($urandom));
      end
      check("R8 random stream", 32'(crcOut), 32'(ref_c));
    end

    rst = 1; @(posedge clk); #1; rst = 0;
    check("R1 reset after use", 32'(crcOut), 32'hFFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule